// File: doc/BRIEF.md
# Sparse Outer-Product Row Scaler

This engine carries out one multiply task of a sparse matrix product built from outer products. A task pairs one nonzero scalar from a column of the left matrix, tagged with its row number, with the nonzeros of the matching row of the right matrix. That row arrives as a valid/ready stream of (column index, value) elements. Each element yields exactly one tagged record: the scalar's row, the element's column, and the product of the two values. The records of one task together form one partial row of the result. Each task ends with a separate end-of-row marker record.

There is no index comparison anywhere in the path. Every element that arrives is multiplied and sent out in the order it arrived, whatever its column index. Nothing is kept from one task to the next except the descriptor latched for the current task. A scheduler that wants a sparse matrix times sparse vector product only issues descriptors for columns whose index matches a nonzero of the vector.

The task descriptor has its own valid/ready port. An empty flag on the descriptor marks a row with no nonzeros. Products are signed fixed-point values: the full signed product, shifted right by a parameterised number of fraction bits and sized to the output width. With the default parameters the full 32-bit product is passed through unchanged.

Top module: `opx_row_scaler`

## Requirements
- R1: After reset `desc_ready` is 1, and `brow_ready` and `pp_valid` are 0.
- R2: Each accepted row element produces exactly one record with `pp_eor`=0. Its `pp_row` equals the row of the current descriptor, its `pp_col` equals the element's column, and its `pp_prod` equals the signed product of the descriptor scalar and the element value, as 32 bits with default parameters.
- R3: The engine does no index matching. Elements with repeated or out-of-order column indices each give their own record, and records leave in input order.
- R4: A record is valid at the output in the cycle right after its element is accepted.
- R5: After the product of the element flagged `brow_last`, the engine emits one marker record: `pp_eor`=1, `pp_row` set to the task row, and `pp_col`=0 and `pp_prod`=0.
- R6: A descriptor with `desc_empty`=1 produces only the marker record and accepts no row elements.
- R7: `desc_ready` is high only between tasks, and `brow_ready` is never high at the same time. After the descriptor is accepted, `desc_ready` stays low until the marker has been loaded into the output stage.
- R8: While `pp_valid`=1 and `pp_ready`=0, the output record holds stable and `brow_ready` is 0, so no record is lost or duplicated.
- R9: Each task's products use only that task's scalar and row. The same engine gives correct results for back-to-back tasks with different scalars.
- R10: Extreme operands give exact results: -32768 × -32768 = 0x40000000, and 32767 × -32768 = 0xC0008000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Task descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor accepted |
| desc_empty | input | 1 | Task row has no nonzeros |
| desc_row | input | RW (16) | Row index of the scalar |
| desc_scale | input | DW (16) | Signed scalar value |
| brow_valid | input | 1 | Row element offered |
| brow_ready | output | 1 | Row element accepted |
| brow_col | input | CW (16) | Column index of the element |
| brow_val | input | DW (16) | Signed element value |
| brow_last | input | 1 | Final element of the row |
| pp_valid | output | 1 | Output record valid |
| pp_ready | input | 1 | Downstream accepts the record |
| pp_row | output | RW (16) | Row tag |
| pp_col | output | CW (16) | Column tag, 0 on a marker |
| pp_prod | output | PW (32) | Product, 0 on a marker |
| pp_eor | output | 1 | End-of-partial-row marker |

## Verification
The output stage can be loaded with a new product in the same cycle that downstream takes the previous record. In that cycle a record is handed over and replaced at one edge. The bench provokes this by streaming elements while `pp_ready` follows a pseudo-random pattern. Every handed-over record is compared, in order, against a queue of records computed arithmetically from the inputs. During stalls, every held record is checked for stability and `brow_ready` is checked to be low. A missing, repeated or altered record in this overlap therefore shows up as a sequence mismatch.

// File: rtl/opx_pkg.sv
package opx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_MARK = 2'd2
   } opx_state_e;
endpackage

// File: rtl/opx_mul_unit.sv
module opx_mul_unit #(
   parameter int DW         = 16,
   parameter int PW         = 32,
   parameter int FRAC_SHIFT = 0
) (
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   output logic [PW-1:0] prod
);
   localparam int FW = 2 * DW;

   logic signed [FW-1:0] full;
   logic signed [FW-1:0] scaled;

   assign full = $signed(op_a) * $signed(op_b);

   generate
      if (FRAC_SHIFT == 0) begin : g_noshift
         assign scaled = full;
      end else begin : g_shift
         assign scaled = full >>> FRAC_SHIFT;
      end

      if (PW == FW) begin : g_same
         assign prod = scaled;
      end else if (PW > FW) begin : g_ext
         assign prod = {{(PW-FW){scaled[FW-1]}}, scaled};
      end else begin : g_trunc
         assign prod = scaled[PW-1:0];
      end
   endgenerate
endmodule

// File: rtl/opx_task_fsm.sv
module opx_task_fsm
   import opx_pkg::*;
#(
   parameter int RW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          desc_valid,
   input  logic          desc_empty,
   input  logic [RW-1:0] desc_row,
   input  logic [DW-1:0] desc_scale,
   output logic          desc_ready,
   input  logic          brow_valid,
   input  logic          brow_last,
   output logic          brow_ready,
   input  logic          slot_free,
   output logic [RW-1:0] row_q,
   output logic [DW-1:0] scale_q,
   output logic          load_prod,
   output logic          load_mark
);
   opx_state_e state_q, state_d;

   assign desc_ready = (state_q == ST_IDLE);
   assign brow_ready = (state_q == ST_ROW) && slot_free;
   assign load_prod  = brow_valid && brow_ready;
   assign load_mark  = (state_q == ST_MARK) && slot_free;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (desc_valid) state_d = desc_empty ? ST_MARK : ST_ROW;
         ST_ROW:  if (load_prod && brow_last) state_d = ST_MARK;
         ST_MARK: if (load_mark) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         scale_q <= '0;
      end else begin
         state_q <= state_d;
         if (desc_valid && desc_ready) begin
            row_q   <= desc_row;
            scale_q <= desc_scale;
         end
      end
   end
endmodule

// File: rtl/opx_rec_reg.sv
module opx_rec_reg #(
   parameter int RW = 16,
   parameter int CW = 16,
   parameter int PW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [RW-1:0] in_row,
   input  logic [CW-1:0] in_col,
   input  logic [PW-1:0] in_prod,
   input  logic          in_eor,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [RW-1:0] out_row,
   output logic [CW-1:0] out_col,
   output logic [PW-1:0] out_prod,
   output logic          out_eor,
   output logic          slot_free
);
   assign slot_free = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_row   <= '0;
         out_col   <= '0;
         out_prod  <= '0;
         out_eor   <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_row   <= in_row;
         out_col   <= in_col;
         out_prod  <= in_prod;
         out_eor   <= in_eor;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/opx_row_scaler.sv
module opx_row_scaler #(
   parameter int RW         = 16,
   parameter int CW         = 16,
   parameter int DW         = 16,
   parameter int PW         = 32,
   parameter int FRAC_SHIFT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          desc_valid,
   output logic          desc_ready,
   input  logic          desc_empty,
   input  logic [RW-1:0] desc_row,
   input  logic [DW-1:0] desc_scale,
   input  logic          brow_valid,
   output logic          brow_ready,
   input  logic [CW-1:0] brow_col,
   input  logic [DW-1:0] brow_val,
   input  logic          brow_last,
   output logic          pp_valid,
   input  logic          pp_ready,
   output logic [RW-1:0] pp_row,
   output logic [CW-1:0] pp_col,
   output logic [PW-1:0] pp_prod,
   output logic          pp_eor
);
   generate
      if (RW < 1 || CW < 1 || DW < 2 || PW < 2)
         $error("opx_row_scaler: widths too small");
      if (FRAC_SHIFT < 0 || FRAC_SHIFT >= 2 * DW)
         $error("opx_row_scaler: FRAC_SHIFT out of range");
   endgenerate

   logic          slot_free;
   logic          load_prod;
   logic          load_mark;
   logic [RW-1:0] row_q;
   logic [DW-1:0] scale_q;
   logic [PW-1:0] prod_w;
   logic [CW-1:0] rec_col;
   logic [PW-1:0] rec_prod;

   opx_task_fsm #(.RW(RW), .DW(DW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_valid (desc_valid),
      .desc_empty (desc_empty),
      .desc_row   (desc_row),
      .desc_scale (desc_scale),
      .desc_ready (desc_ready),
      .brow_valid (brow_valid),
      .brow_last  (brow_last),
      .brow_ready (brow_ready),
      .slot_free  (slot_free),
      .row_q      (row_q),
      .scale_q    (scale_q),
      .load_prod  (load_prod),
      .load_mark  (load_mark)
   );

   opx_mul_unit #(.DW(DW), .PW(PW), .FRAC_SHIFT(FRAC_SHIFT)) u_mul (
      .op_a (scale_q),
      .op_b (brow_val),
      .prod (prod_w)
   );

   assign rec_col  = load_mark ? '0 : brow_col;
   assign rec_prod = load_mark ? '0 : prod_w;

   opx_rec_reg #(.RW(RW), .CW(CW), .PW(PW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_prod || load_mark),
      .in_row    (row_q),
      .in_col    (rec_col),
      .in_prod   (rec_prod),
      .in_eor    (load_mark),
      .out_valid (pp_valid),
      .out_ready (pp_ready),
      .out_row   (pp_row),
      .out_col   (pp_col),
      .out_prod  (pp_prod),
      .out_eor   (pp_eor),
      .slot_free (slot_free)
   );
endmodule

// File: rtl/opx_row_scaler_chk.sv
module opx_row_scaler_chk #(
   parameter int RW = 16,
   parameter int CW = 16,
   parameter int PW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          desc_valid,
   input logic          desc_ready,
   input logic [RW-1:0] desc_row,
   input logic          brow_valid,
   input logic          brow_ready,
   input logic [CW-1:0] brow_col,
   input logic          brow_last,
   input logic          pp_valid,
   input logic          pp_ready,
   input logic [RW-1:0] pp_row,
   input logic [CW-1:0] pp_col,
   input logic [PW-1:0] pp_prod,
   input logic          pp_eor
);
   logic [RW-1:0] trk_row;

   always_ff @(posedge clk) begin
      if (!rst_n) trk_row <= '0;
      else if (desc_valid && desc_ready) trk_row <= desc_row;
   end

   assert_row_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && !pp_eor) |-> (pp_row == trk_row));

   assert_prod_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (brow_valid && brow_ready) |=> (pp_valid && !pp_eor && pp_col == $past(brow_col)));

   assert_marker_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && pp_eor) |-> (pp_col == '0 && pp_prod == '0));

   assert_one_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ready |-> !brow_ready);

   assert_no_desc_midtask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brow_valid && brow_ready && !brow_last) |=> !desc_ready);

   assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && !pp_ready) |=> (pp_valid && $stable(pp_row) && $stable(pp_col)
                                   && $stable(pp_prod) && $stable(pp_eor)));

   assert_input_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && !pp_ready) |-> !brow_ready);
endmodule

bind opx_row_scaler opx_row_scaler_chk #(.RW(RW), .CW(CW), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .desc_valid (desc_valid),
   .desc_ready (desc_ready),
   .desc_row   (desc_row),
   .brow_valid (brow_valid),
   .brow_ready (brow_ready),
   .brow_col   (brow_col),
   .brow_last  (brow_last),
   .pp_valid   (pp_valid),
   .pp_ready   (pp_ready),
   .pp_row     (pp_row),
   .pp_col     (pp_col),
   .pp_prod    (pp_prod),
   .pp_eor     (pp_eor)
);

// File: tb/tb_opx_row_scaler.sv
module tb_opx_row_scaler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_valid = 1'b0;
   logic        desc_ready;
   logic        desc_empty = 1'b0;
   logic [15:0] desc_row = '0;
   logic [15:0] desc_scale = '0;
   logic        brow_valid = 1'b0;
   logic        brow_ready;
   logic [15:0] brow_col = '0;
   logic [15:0] brow_val = '0;
   logic        brow_last = 1'b0;
   logic        pp_valid;
   logic        pp_ready = 1'b1;
   logic [15:0] pp_row;
   logic [15:0] pp_col;
   logic [31:0] pp_prod;
   logic        pp_eor;

   always #5 clk = ~clk;

   opx_row_scaler dut (
      .clk(clk), .rst_n(rst_n),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_empty(desc_empty),
      .desc_row(desc_row), .desc_scale(desc_scale),
      .brow_valid(brow_valid), .brow_ready(brow_ready), .brow_col(brow_col),
      .brow_val(brow_val), .brow_last(brow_last),
      .pp_valid(pp_valid), .pp_ready(pp_ready), .pp_row(pp_row), .pp_col(pp_col),
      .pp_prod(pp_prod), .pp_eor(pp_eor)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // expected record queue: {row, col, prod, eor}
   logic [64:0] exp_q [0:1023];
   int wr_ptr = 0;
   int rd_ptr = 0;

   task automatic check(input bit ok, input string req, input logic [64:0] act,
                        input logic [64:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] mul32(input int a, input int b);
      longint p;
      p = longint'(a) * longint'(b);
      return p[31:0];
   endfunction

   function automatic int aval(input int i);
      case (i)
         0: return 0;
         1: return 1;
         2: return -1;
         3: return 32767;
         4: return -32768;
         default: return -1234;
      endcase
   endfunction

   function automatic int bval(input int i);
      case (i % 6)
         0: return 0;
         1: return 5;
         2: return -7;
         3: return 32767;
         4: return -32768;
         default: return 300;
      endcase
   endfunction

   // output monitor: ready pattern set at negedge, handshake judged before posedge
   logic [15:0] lfsr = 16'hACE1;
   bit stall_mode = 0;
   bit was_stalled = 0;
   logic [64:0] held;

   always @(negedge clk) begin
      if (rst_n) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pp_ready = stall_mode ? lfsr[0] : 1'b1;
         #3;
         if (was_stalled) begin
            check(pp_valid && {pp_row, pp_col, pp_prod, pp_eor} == held,
                  "R8 held record", {pp_row, pp_col, pp_prod, pp_eor}, held);
         end
         was_stalled = 0;
         if (pp_valid && !pp_ready) begin
            check(!brow_ready, "R8 input stalled", 65'(brow_ready), 65'd0);
            held = {pp_row, pp_col, pp_prod, pp_eor};
            was_stalled = 1;
         end else if (pp_valid && pp_ready) begin
            if (rd_ptr < wr_ptr) begin
               check({pp_row, pp_col, pp_prod, pp_eor} == exp_q[rd_ptr],
                     pp_eor ? "R5 marker record" : "R2 R3 product record",
                     {pp_row, pp_col, pp_prod, pp_eor}, exp_q[rd_ptr]);
            end else begin
               check(0, "R2 unexpected record", {pp_row, pp_col, pp_prod, pp_eor}, '0);
            end
            rd_ptr++;
         end
      end
   end

   task automatic send_desc(input int row, input int a, input bit empty);
      desc_valid = 1'b1;
      desc_row = row[15:0];
      desc_scale = a[15:0];
      desc_empty = empty;
      if (empty) begin
         exp_q[wr_ptr] = {row[15:0], 16'd0, 32'd0, 1'b1};
         wr_ptr++;
      end
      #1;
      while (!desc_ready) begin
         @(negedge clk);
         #1;
      end
      check(!brow_ready, "R7 ready exclusive", 65'(brow_ready), 65'd0);
      @(negedge clk);
      desc_valid = 1'b0;
      desc_empty = 1'b0;
      if (!empty) check(!desc_ready, "R7 busy after accept", 65'(desc_ready), 65'd0);
   endtask

   task automatic send_elem(input int row, input int a, input int col, input int b,
                            input bit last);
      brow_valid = 1'b1;
      brow_col = col[15:0];
      brow_val = b[15:0];
      brow_last = last;
      exp_q[wr_ptr] = {row[15:0], col[15:0], mul32(a, b), 1'b0};
      wr_ptr++;
      if (last) begin
         exp_q[wr_ptr] = {row[15:0], 16'd0, 32'd0, 1'b1};
         wr_ptr++;
      end
      #1;
      while (!brow_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      brow_valid = 1'b0;
      brow_last = 1'b0;
      check(pp_valid && !pp_eor && pp_col == col[15:0], "R4 record next cycle",
            {pp_valid, pp_eor, pp_col}, {1'b1, 1'b0, col[15:0]});
   endtask

   task automatic run_task(input int row, input int a, input int len, input int seed);
      send_desc(row, a, len == 0);
      for (int j = 0; j < len; j++) begin
         // column pattern repeats for j=0,1 and is not sorted (R3)
         send_elem(row, a, (seed + (j >> 1) * 7) % 9, bval(j + seed), j == len - 1);
      end
   endtask

   task automatic drain();
      for (int w = 0; w < 200 && rd_ptr < wr_ptr; w++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(desc_ready && !brow_ready && !pp_valid, "R1 reset state",
            {desc_ready, brow_ready, pp_valid}, 65'b100);
      @(negedge clk);
      for (int ph = 0; ph < 2; ph++) begin
         stall_mode = (ph == 1);
         for (int ai = 0; ai < 6; ai++) begin
            for (int len = 0; len < 5; len++) begin
               // back-to-back tasks with different scalars (R9), empty rows (R6)
               run_task(ai * 11 + len + 3 + ph * 100, aval(ai), len, ai + len);
            end
         end
      end
      stall_mode = 0;
      // R10 extremes
      send_desc(16'h7777, -32768, 1'b0);
      send_elem(16'h7777, -32768, 1, -32768, 1'b0);
      send_elem(16'h7777, -32768, 2, 32767, 1'b1);
      send_desc(16'h0001, 32767, 1'b0);
      send_elem(16'h0001, 32767, 3, -32768, 1'b1);
      check(mul32(-32768, -32768) == 32'h40000000, "R10 reference", 65'(mul32(-32768, -32768)),
            65'h40000000);
      // R6 empty row: only a marker, element port never ready
      send_desc(16'h0abc, 9, 1'b1);
      #1;
      check(!brow_ready, "R6 no element accepted", 65'(brow_ready), 65'd0);
      drain();
      check(rd_ptr == wr_ptr, "R2 all records delivered", 65'(rd_ptr), 65'(wr_ptr));
      #1;
      check(desc_ready && !pp_valid, "R7 idle after drain", {desc_ready, pp_valid}, 65'b10);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", rd_ptr, wr_ptr);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule